// File: doc/BRIEF.md
# Open-Drain Serial Clock Generator with Multi-Master Synchronization

This block produces the clock waveform of a two-wire serial bus on a shared open-drain line. It never drives the line high. It either pulls the line low or lets it float, and it reads back the real line level through a synchronizer. The low and high phases are timed in system-clock cycles from two programmable counts.

Because the line is a wired-AND, every device that pulls low holds the line low. After its own low phase ends, the block releases the line. It then waits in a stretch state until the line really reads high, and only then starts timing its high phase. If any other device pulls the line low during the high phase, the block drops the rest of that phase and starts a fresh low phase at once. As a result, the slowest participant sets the bus low time and the fastest sets the bus high time. A slave can also hold the clock low for as long as it needs.

The data path receives one-cycle strobes on the rising and falling edges of the line as seen after the synchronizer. It also receives a pulse when the local low phase ends. Start and stop conditions and bit shifting belong to other blocks.

Top module: `scl_clock_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `scl_pull`, `stretch`, `low_done`, `rise_stb` and `fall_stb` are all 0.
- R2: Each local low phase drives `scl_pull` high for exactly max(`low_cnt`, 3) consecutive cycles, whether or not another device also holds the line low.
- R3: After the low phase, the block keeps `scl_pull` at 0. While the synchronized line still reads low, it holds `stretch` at 1.
- R4: Timing of the high phase starts only once the synchronized line reads high. With no other device active, the line stays high for max(`high_cnt`, 4) cycles. Three of those cycles cover the input synchronizer and the state change.
- R5: The line may be pulled low by another device during the high phase, with the line going low just after clock edge E. Then `scl_pull` rises at edge E+3, and a full local low phase of max(`low_cnt`, 3) cycles follows.
- R6: `low_done` is a one-cycle pulse. It is 1 exactly in the first cycle in which `scl_pull` has returned to 0 at the end of a low phase while `en` was 1.
- R7: `rise_stb` (or `fall_stb`) is 1 for one cycle. That cycle starts on the second clock edge after the edge following a low-to-high (or high-to-low) change of `scl_i`. At no other time is it 1.
- R8: When `en` is 0 at a clock edge, `scl_pull` is 0 after that edge and stays 0. When `en` is 1 at an edge while the block is idle, `scl_pull` becomes 1 after that edge.
- R9: After an external device releases a stretched low at edge F, the line stays high for max(`high_cnt`, 4) cycles before the block pulls it low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock generation enable; 0 releases the line |
| low_cnt | input | CNT_W | Requested low-phase length in system cycles |
| high_cnt | input | CNT_W | Requested high-phase length in system cycles |
| scl_i | input | 1 | Raw level read back from the clock line |
| scl_pull | output | 1 | 1 pulls the clock line low; 0 releases it |
| stretch | output | 1 | Line released locally but still held low elsewhere |
| low_done | output | 1 | Pulse: local low phase finished |
| rise_stb | output | 1 | Pulse: synchronized line rose |
| fall_stb | output | 1 | Pulse: synchronized line fell |

## Verification
The embedded properties check several rules on every cycle. The block never pulls the line while it reports a stretch. A seen fall during the high phase always restarts the low phase. The wait state holds until the line reads high and then always moves to high timing. The end-of-low pulse always matches a release, and a deasserted enable always leaves the line free. The exact phase lengths can only be shown by the bench scenarios that measure the line. These cover the sweep of low and high counts with their floors, the three-cycle reaction to a foreign pull-down, and the high time after a slave stretch. The same holds for the fixed two-cycle lag of the edge strobes.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HIGH = 2'd3
    } phase_t;

    typedef struct packed {
        logic load;
        logic dec;
    } tmr_cmd_t;

    // Low phase must outlast the synchronizer so the wait state sees the line low.
    function automatic int low_floor(int req, int stages);
        int lim;
        lim = stages + 1;
        return (req < lim) ? lim : req;
    endfunction

    // High phase counting starts after the line is seen high; deduct that latency.
    function automatic int high_net(int req, int stages);
        int allow;
        allow = stages + 1;
        return (req <= allow) ? 1 : req - allow;
    endfunction

endpackage

// File: rtl/sclg_sync.sv
module sclg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level,
    output logic rise,
    output logic fall
);
    // chain[0] newest sample, chain[STAGES-1] synchronized level, chain[STAGES] previous level
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], line_i};
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
    assign fall  = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/sclg_timer.sv
module sclg_timer
    import sclg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_cmd_t      cmd,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cmd.load) begin
            cnt_q <= load_val;
        end else if (cmd.dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q <= CW'(1));

    // R2: a phase is never loaded with a zero length
    p_load_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.load |-> (load_val != '0));

endmodule

// File: rtl/sclg_fsm.sv
module sclg_fsm
    import sclg_pkg::*;
#(
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] low_cnt,
    input  logic [CW-1:0] high_cnt,
    input  logic          level,
    input  logic          fall,
    input  logic          expired,
    output tmr_cmd_t      cmd,
    output logic [CW-1:0] load_val,
    output logic          pull,
    output logic          done,
    output phase_t        phase
);
    phase_t        state, nxt;
    logic          sel_high;
    logic [CW-1:0] low_load, high_load;

    assign low_load  = CW'(low_floor(int'(low_cnt), STAGES));
    assign high_load = CW'(high_net(int'(high_cnt), STAGES));
    assign load_val  = sel_high ? high_load : low_load;

    always_comb begin
        nxt      = state;
        cmd      = '0;
        sel_high = 1'b0;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt      = ST_LOW;
                    cmd.load = 1'b1;
                end
                ST_LOW: begin
                    if (expired) nxt = ST_WAIT;
                    else         cmd.dec = 1'b1;
                end
                ST_WAIT: begin
                    if (level) begin
                        nxt      = ST_HIGH;
                        cmd.load = 1'b1;
                        sel_high = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (fall || expired) begin
                        nxt      = ST_LOW;
                        cmd.load = 1'b1;
                    end else begin
                        cmd.dec = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pull  <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            pull  <= (nxt == ST_LOW);
            done  <= (state == ST_LOW) && (nxt == ST_WAIT);
        end
    end

    assign phase = state;

    // R3: stay in the wait state while the line is still seen low
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !level && en) |=> (state == ST_WAIT));

    // R4: a seen high level always starts high timing
    p_wait_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && level && en) |=> (state == ST_HIGH));

    // R5: a foreign pull-down in the high phase restarts the low phase
    p_fall_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && fall && en) |=> (state == ST_LOW && pull));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import sclg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             scl_i,
    output logic             scl_pull,
    output logic             stretch,
    output logic             low_done,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic          line_lvl;
    logic          expired;
    tmr_cmd_t      cmd;
    logic [CNT_W-1:0] load_val;
    phase_t        phase;

    sclg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (scl_i),
        .level  (line_lvl),
        .rise   (rise_stb),
        .fall   (fall_stb)
    );

    sclg_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (load_val),
        .expired  (expired)
    );

    sclg_fsm #(.CW(CNT_W), .STAGES(SYNC_STAGES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .level    (line_lvl),
        .fall     (fall_stb),
        .expired  (expired),
        .cmd      (cmd),
        .load_val (load_val),
        .pull     (scl_pull),
        .done     (low_done),
        .phase    (phase)
    );

    assign stretch = (phase == ST_WAIT);

    // R8: disable releases the line at the next edge
    p_off_release_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !scl_pull);

    // R6: end-of-low pulse coincides with a release
    p_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
        low_done |-> (!scl_pull && $past(scl_pull)));

    // R3: never pulling while reporting a stretch
    p_stretch_free_r3: assert property (@(posedge clk) disable iff (rst)
        stretch |-> !scl_pull);

endmodule

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, en, ext_low;
    logic [CW-1:0] lo_cnt, hi_cnt;
    logic          pull, stretch, done, rise, fall;
    logic          line;

    assign line = !(pull || ext_low);

    scl_clock_gen #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .en(en), .low_cnt(lo_cnt), .high_cnt(hi_cnt),
        .scl_i(line), .scl_pull(pull), .stretch(stretch), .low_done(done),
        .rise_stb(rise), .fall_stb(fall)
    );

    int total = 0, bad = 0;
    int rf_bad = 0, ld_bad = 0, ld_miss = 0, rise_seen = 0;
    logic h0 = 1'b1, h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
    logic prev_drv = 1'b0, prev_en = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sample per cycle, at the falling clock edge, with running monitors
    task automatic tick();
        @(negedge clk);
        h3 = h2; h2 = h1; h1 = h0; h0 = line;
        if (!rst) begin
            if (rise != (h2 && !h3)) rf_bad++;   // R7 rise lag
            if (fall != (!h2 && h3)) rf_bad++;   // R7 fall lag
            if (rise) rise_seen++;
            if (done && !(prev_drv && !pull)) ld_bad++;            // R6
            if (prev_drv && !pull && prev_en && !done) ld_miss++;  // R6
        end
        prev_drv = pull;
        prev_en  = en;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1; en = v;
    endtask

    task automatic set_ext(input logic v);
        @(posedge clk); #1; ext_low = v;
    endtask

    task automatic measure(output int lo, output int hi);
        while (line) tick();
        while (!line) tick();
        hi = 0;
        while (line) begin hi++; tick(); end
        lo = 0;
        while (!line) begin lo++; tick(); end
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a, b, n;
        rst = 1'b1; en = 1'b0; ext_low = 1'b0; lo_cnt = 8'd5; hi_cnt = 8'd6;
        repeat (3) tick();
        check(!pull && !stretch && !done, "R1 in reset", int'(pull) + int'(stretch) + int'(done), 0);
        @(posedge clk); #1; rst = 1'b0;
        tick();
        check(!pull && !stretch && !done && !rise && !fall, "R1 after reset",
              int'(pull) + int'(stretch) + int'(done) + int'(rise) + int'(fall), 0);

        // R2 / R4 sweep over low and high counts
        for (int l = 0; l <= 6; l++) begin
            for (int h = 0; h <= 7; h++) begin
                set_en(1'b0);
                repeat (3) tick();
                lo_cnt = CW'(l); hi_cnt = CW'(h);
                set_en(1'b1);
                measure(a, b);
                measure(a, b);
                check(a == maxi(l, 3), $sformatf("R2 low l=%0d h=%0d", l, h), a, maxi(l, 3));
                check(b == maxi(h, 4), $sformatf("R4 high l=%0d h=%0d", l, h), b, maxi(h, 4));
            end
        end

        // R8 disable and restart
        lo_cnt = 8'd5; hi_cnt = 8'd6;
        while (!pull) tick();
        set_en(1'b0);
        tick(); tick();
        check(!pull, "R8 release", int'(pull), 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin tick(); if (pull || !line) n++; end
        check(n == 0, "R8 stays released", n, 0);
        set_en(1'b1);
        tick(); tick();
        check(pull, "R8 start", int'(pull), 1);

        // R5 foreign pull-down during a long high phase
        lo_cnt = 8'd5; hi_cnt = 8'd20;
        measure(a, b);
        measure(a, b);
        check(b == 20, "R4 long high", b, 20);
        repeat (3) tick();
        check(line && !pull, "R5 still high", int'(line), 1);
        set_ext(1'b1);
        tick();
        n = 1;
        while (!pull) begin tick(); n++; end
        check(n == 4, "R5 reaction delay", n, 4);
        set_ext(1'b0);
        n = 1;
        tick();
        while (pull) begin n++; tick(); end
        check(n == 5, "R5 full low after restart", n, 5);

        // R9 / R3 slave stretch
        hi_cnt = 8'd6;
        measure(a, b);
        while (!pull) tick();
        set_ext(1'b1);
        n = 1;
        tick();
        while (pull) begin n++; tick(); end
        check(n == 5, "R2 low under stretch", n, 5);
        repeat (4) tick();
        check(stretch && !pull && !line, "R3 stretch held", int'(stretch), 1);
        set_ext(1'b0);
        tick();
        n = 0;
        while (line) begin n++; tick(); end
        check(n == 6, "R9 high after stretch", n, 6);
        check(!stretch, "R3 stretch cleared", int'(stretch), 0);

        repeat (20) tick();
        check(rf_bad == 0, "R7 strobe timing", rf_bad, 0);
        check(rise_seen > 0, "R7 strobes seen", rise_seen, 1);
        check(ld_bad == 0, "R6 spurious low_done", ld_bad, 0);
        check(ld_miss == 0, "R6 missing low_done", ld_miss, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule